// File: doc/BRIEF.md
# Timer Waveform Generation Unit

A four-channel timer waveform generator. One counter runs against a TOP value. In most modes TOP is the period input. In match-frequency mode TOP is the compare value of channel 0. Each channel compares the counter with its own compare value. It turns the result into a waveform bit according to the active mode. That bit then passes through a per-channel polarity inversion and a per-pair output swap. The block also gives an overflow pulse, the counting direction and the counter value.

Mode, polarity, swap and the two circular-enable settings are written into buffer registers through one write strobe. The circular enables are passed to neighbouring compare-buffer logic as outputs. When double buffering is off, a write takes effect in the active fields at once. When it is on, the active fields copy the buffers only at the edge that ends an update-condition cycle. The update points depend on the mode.

The counter direction is a two-state machine:
- `ST_UP`: the counter increments.
- `ST_DOWN`: the counter decrements.

Its transitions are:
- **top turn**, `ST_UP`→`ST_DOWN`: in a dual-slope mode when the counter is at TOP.
- **zero turn**, `ST_DOWN`→`ST_UP`: in a dual-slope mode when the counter is at zero.
- **follow**: in a single-slope mode the state tracks the `count_down` input, whether or not the counter runs.

Dual-slope TOP is assumed to be at least 1.

Top module: `tmr_wave_unit`

## Requirements
- R1: After reset the buffer fields and the active fields are zero and the counter is 0. The direction, overflow and all waveform outputs are 0.
- R2: In single-slope modes (mode 0 = normal frequency, 2 = normal PWM) with TOP = `period`, counting up goes 0,1,…,TOP,0. With `count_down`=1 the counter goes from 0 to TOP, then TOP-1, …, 0. `dir_o` is 0 when counting up and 1 when counting down.
- R3: In mode 1 (match frequency), TOP is channel 0's compare value (`cmp[7:0]` by default) and `period` is ignored.
- R4: In dual-slope modes (mode 4 = critical, 5 = bottom, 6 = both, 7 = top) the counter goes 0 up to `period` and back down to 0. TOP and zero each last one cycle. `dir_o` is 0 from zero up to and including TOP, and 1 from the cycle after TOP up to and including zero.
- R5: `ovf_o` is high for one cycle:
  - in single-slope modes, at TOP when counting up and at zero when counting down;
  - in modes 4 and 5, at zero only;
  - in mode 6, at both TOP and zero;
  - in mode 7, at TOP only.
- R6: In modes 0 and 1 a channel's waveform bit toggles on the edge that ends a cycle where counter equals its compare value.
- R7: In mode 2 a channel's waveform bit is set on a compare match and cleared on an update. If both happen in the same cycle, the clear wins.
- R8: In dual-slope modes a compare match loads the waveform bit with the inverse of `dir_o` (1 on the way up, 0 on the way down).
- R9: The reserved mode value 3 behaves exactly as mode 0.
- R10: `wave_out` bit i is the channel waveform XOR the active polarity bit i.
- R11: Swap bit k exchanges `wave_out` bits 2k and 2k+1. The swap is applied after polarity.
- R12: With `dbuf_en`=0, a write reaches the active fields on the same edge as the buffers. With `dbuf_en`=1, the active fields change only on the edge ending an update cycle, where they copy the buffers. Update cycles are:
  - in single-slope modes, TOP counting up or zero counting down;
  - in modes 4, 5 and 7, zero;
  - in mode 6, TOP and zero.
- R13: While `run_en` is 0 the counter holds its value and no overflow or update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Counter runs when high |
| dbuf_en | input | 1 | Double buffering of configuration |
| count_down | input | 1 | Single-slope counting direction |
| cfg_we | input | 1 | Write strobe for the buffer fields |
| cfg_mode | input | 3 | Waveform mode to write |
| cfg_pol | input | NCH | Per-channel polarity to write |
| cfg_swap | input | NCH/2 | Per-pair swap to write |
| cfg_circ_cc | input | NCH | Per-channel circular-compare enable to write |
| cfg_circ_per | input | 1 | Circular-period enable to write |
| period | input | CW | Period value (TOP in most modes) |
| cmp | input | NCH*CW | Compare values, channel i at bits i*CW upward |
| wave_out | output | NCH | Channel waveform outputs |
| ovf_o | output | 1 | Overflow pulse |
| dir_o | output | 1 | Counter direction (1 = down) |
| count_o | output | CW | Counter value |
| circ_cc_o | output | NCH | Active circular-compare enables |
| circ_per_o | output | 1 | Active circular-period enable |

## Verification
Several properties are checked on every cycle by assertions:
- the counter holds and no overflow or update fires while halted;
- single-slope wrap to zero and the dual-slope turn at TOP;
- overflow in the bottom-only modes occurring only at zero while counting down;
- the toggle, set/clear and inverse-of-direction reactions to a compare match;
- active fields staying put between updates while double buffering is on.

Other behaviour is shown only by the bench scenarios:
- the full period shape of the counter in every mode;
- the phase of each waveform against its compare value;
- the reserved mode matching mode 0;
- the exact cycle where a buffered write, including a mode change, first shows;
- the polarity and swap ordering at the outputs.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

    typedef enum logic [2:0] {
        WG_NFRQ    = 3'd0,
        WG_MFRQ    = 3'd1,
        WG_NPWM    = 3'd2,
        WG_RSVD    = 3'd3,
        WG_DS_CRIT = 3'd4,
        WG_DS_BOT  = 3'd5,
        WG_DS_BOTH = 3'd6,
        WG_DS_TOP  = 3'd7
    } wg_mode_e;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/tmr_cfg_bank.sv
module tmr_cfg_bank #(
    parameter int NCH = 4,
    localparam int NPAIR = NCH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbuf_en,
    input  logic             upd,
    input  logic             wr_en,
    input  logic [2:0]       mode_in,
    input  logic [NCH-1:0]   pol_in,
    input  logic [NPAIR-1:0] swap_in,
    input  logic [NCH-1:0]   cc_in,
    input  logic             per_in,
    output logic [2:0]       mode_q,
    output logic [NCH-1:0]   pol_q,
    output logic [NPAIR-1:0] swap_q,
    output logic [NCH-1:0]   cc_q,
    output logic             per_q
);

    logic [2:0]       mode_b;
    logic [NCH-1:0]   pol_b;
    logic [NPAIR-1:0] swap_b;
    logic [NCH-1:0]   cc_b;
    logic             per_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_b <= '0;
            pol_b  <= '0;
            swap_b <= '0;
            cc_b   <= '0;
            per_b  <= 1'b0;
        end else if (wr_en) begin
            mode_b <= mode_in;
            pol_b  <= pol_in;
            swap_b <= swap_in;
            cc_b   <= cc_in;
            per_b  <= per_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '0;
            swap_q <= '0;
            cc_q   <= '0;
            per_q  <= 1'b0;
        end else if (!dbuf_en && wr_en) begin
            mode_q <= mode_in;
            pol_q  <= pol_in;
            swap_q <= swap_in;
            cc_q   <= cc_in;
            per_q  <= per_in;
        end else if (dbuf_en && upd) begin
            mode_q <= mode_b;
            pol_q  <= pol_b;
            swap_q <= swap_b;
            cc_q   <= cc_b;
            per_q  <= per_b;
        end
    end

    // R12
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en && !upd) |=> ($stable(mode_q) && $stable(pol_q) && $stable(swap_q)
                               && $stable(cc_q) && $stable(per_q)));

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
    import tmr_wave_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          count_down,
    input  wg_mode_e      mode,
    input  logic [CW-1:0] top,
    output logic [CW-1:0] cnt_q,
    output logic          dir_o,
    output logic          ovf_o,
    output logic          upd_o
);

    cnt_dir_e      state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic          dual, at_top, at_zero;

    assign dual    = mode[2];
    assign at_top  = (state_q == ST_UP) && (cnt_q >= top);
    assign at_zero = (state_q == ST_DOWN) && (cnt_q == '0);
    assign dir_o   = (state_q == ST_DOWN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UP: begin
                if (!dual)                    state_d = count_down ? ST_DOWN : ST_UP;
                else if (run_en && at_top)    state_d = ST_DOWN;
            end
            ST_DOWN: begin
                if (!dual)                    state_d = count_down ? ST_DOWN : ST_UP;
                else if (run_en && at_zero)   state_d = ST_UP;
            end
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            ST_UP: begin
                if (at_top) cnt_d = dual ? ((top == '0) ? '0 : top - CW'(1)) : '0;
                else        cnt_d = cnt_q + CW'(1);
            end
            ST_DOWN: begin
                if (cnt_q == '0) cnt_d = dual ? ((top == '0) ? '0 : CW'(1)) : top;
                else             cnt_d = cnt_q - CW'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (run_en) cnt_q <= cnt_d;
    end

    always_comb begin
        ovf_o = 1'b0;
        upd_o = 1'b0;
        if (run_en) begin
            unique case (mode)
                WG_DS_CRIT, WG_DS_BOT: begin
                    ovf_o = at_zero;
                    upd_o = at_zero;
                end
                WG_DS_BOTH: begin
                    ovf_o = at_zero || at_top;
                    upd_o = at_zero || at_top;
                end
                WG_DS_TOP: begin
                    ovf_o = at_top;
                    upd_o = at_zero;
                end
                default: begin
                    ovf_o = at_top || at_zero;
                    upd_o = at_top || at_zero;
                end
            endcase
        end
    end

    // R13
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cnt_q));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!ovf_o && !upd_o));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !dual && !dir_o && cnt_q >= top) |=> (cnt_q == '0));

    // R4
    ds_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && dual && !dir_o && cnt_q == top && top != '0) |=> dir_o);

    // R5
    ds_bot_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && (mode == WG_DS_CRIT || mode == WG_DS_BOT)) |-> (cnt_q == '0 && dir_o));

endmodule

// File: rtl/tmr_wave_ch.sv
module tmr_wave_ch
    import tmr_wave_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     match,
    input  logic     upd,
    input  logic     dir,
    input  wg_mode_e mode,
    output logic     wave_q
);

    logic wave_d;

    always_comb begin
        wave_d = wave_q;
        unique case (mode)
            WG_NFRQ, WG_MFRQ, WG_RSVD: begin
                if (match) wave_d = !wave_q;
            end
            WG_NPWM: begin
                if (upd)        wave_d = 1'b0;
                else if (match) wave_d = 1'b1;
            end
            WG_DS_CRIT, WG_DS_BOT, WG_DS_BOTH, WG_DS_TOP: begin
                if (match) wave_d = !dir;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    // R6
    freq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && (mode == WG_NFRQ || mode == WG_MFRQ)) |=> (wave_q != $past(wave_q)));

    // R7
    pwm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == WG_NPWM) |=> !wave_q);

    // R8
    ds_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode[2]) |=> (wave_q == !$past(dir)));

endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
    import tmr_wave_pkg::*;
#(
    parameter int CW  = 8,
    parameter int NCH = 4,
    localparam int NPAIR = NCH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               dbuf_en,
    input  logic               count_down,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_mode,
    input  logic [NCH-1:0]     cfg_pol,
    input  logic [NPAIR-1:0]   cfg_swap,
    input  logic [NCH-1:0]     cfg_circ_cc,
    input  logic               cfg_circ_per,
    input  logic [CW-1:0]      period,
    input  logic [NCH*CW-1:0]  cmp,
    output logic [NCH-1:0]     wave_out,
    output logic               ovf_o,
    output logic               dir_o,
    output logic [CW-1:0]      count_o,
    output logic [NCH-1:0]     circ_cc_o,
    output logic               circ_per_o
);

    logic [2:0]       mode_q;
    logic [NCH-1:0]   pol_q;
    logic [NPAIR-1:0] swap_q;
    logic             upd;
    wg_mode_e         mode_eff;
    logic [CW-1:0]    top;
    logic [NCH-1:0]   wave;
    logic [NCH-1:0]   pol_w;

    tmr_cfg_bank #(.NCH(NCH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbuf_en (dbuf_en),
        .upd     (upd),
        .wr_en   (cfg_we),
        .mode_in (cfg_mode),
        .pol_in  (cfg_pol),
        .swap_in (cfg_swap),
        .cc_in   (cfg_circ_cc),
        .per_in  (cfg_circ_per),
        .mode_q  (mode_q),
        .pol_q   (pol_q),
        .swap_q  (swap_q),
        .cc_q    (circ_cc_o),
        .per_q   (circ_per_o)
    );

    assign mode_eff = (mode_q == 3'd3) ? WG_NFRQ : wg_mode_e'(mode_q);
    assign top      = (mode_eff == WG_MFRQ) ? cmp[CW-1:0] : period;

    tmr_cnt_core #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .count_down (count_down),
        .mode       (mode_eff),
        .top        (top),
        .cnt_q      (count_o),
        .dir_o      (dir_o),
        .ovf_o      (ovf_o),
        .upd_o      (upd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = run_en && (count_o == cmp[i*CW +: CW]);
        tmr_wave_ch u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .match  (hit),
            .upd    (upd),
            .dir    (dir_o),
            .mode   (mode_eff),
            .wave_q (wave[i])
        );
    end

    assign pol_w = wave ^ pol_q;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign wave_out[2*k]   = swap_q[k] ? pol_w[2*k+1] : pol_w[2*k];
        assign wave_out[2*k+1] = swap_q[k] ? pol_w[2*k]   : pol_w[2*k+1];
    end

    if (NCH % 2 != 0) begin : g_odd
        assign wave_out[NCH-1] = pol_w[NCH-1];
    end

endmodule

// File: tb/tmr_wave_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_wave_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        dbuf_en = 1'b0;
    logic        count_down = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [3:0]  cfg_pol = '0;
    logic [1:0]  cfg_swap = '0;
    logic [3:0]  cfg_circ_cc = '0;
    logic        cfg_circ_per = 1'b0;
    logic [7:0]  period = '0;
    logic [31:0] cmp = '1;
    logic [3:0]  wave_out;
    logic        ovf_o, dir_o, circ_per_o;
    logic [7:0]  count_o;
    logic [3:0]  circ_cc_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_wave_unit dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .dbuf_en(dbuf_en),
        .count_down(count_down), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_pol(cfg_pol), .cfg_swap(cfg_swap), .cfg_circ_cc(cfg_circ_cc),
        .cfg_circ_per(cfg_circ_per), .period(period), .cmp(cmp),
        .wave_out(wave_out), .ovf_o(ovf_o), .dir_o(dir_o), .count_o(count_o),
        .circ_cc_o(circ_cc_o), .circ_per_o(circ_per_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 1'b0; dbuf_en = 1'b0; count_down = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [2:0] m, input logic [3:0] p, input logic [1:0] s,
                             input logic [3:0] cc, input logic per);
        cfg_mode = m; cfg_pol = p; cfg_swap = s; cfg_circ_cc = cc; cfg_circ_per = per;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int e_cnt(int em, int te, int n, bit dn);
        int p;
        if (em < 4) begin
            p = n % (te + 1);
            if (!dn) return p;
            return (p == 0) ? 0 : te + 1 - p;
        end
        p = n % (2 * te);
        return (p <= te) ? p : 2 * te - p;
    endfunction

    function automatic int e_dir(int em, int te, int n, bit dn);
        int p;
        if (em < 4) return dn ? 1 : 0;
        p = n % (2 * te);
        return ((p > te) || (p == 0 && n > 0)) ? 1 : 0;
    endfunction

    function automatic int e_ovf(int em, int te, int n, bit dn);
        int p;
        bit z, t;
        if (em < 4) begin
            p = n % (te + 1);
            return dn ? int'(p == 0) : int'(p == te);
        end
        p = n % (2 * te);
        z = (p == 0) && (n > 0);
        t = (p == te);
        if (em == 6) return int'(z || t);
        if (em == 7) return int'(t);
        return int'(z);
    endfunction

    function automatic int e_wave(int em, int te, int c, int n);
        int q;
        if (n == 0) return 0;
        if (em <= 1) return (n > c) ? (((n - 1 - c) / (te + 1) + 1) & 1) : 0;
        if (em == 2) begin
            q = (n - 1) % (te + 1);
            return int'(q >= c && q < te);
        end
        q = (n - 1) % (2 * te);
        return int'(q >= c && q < 2 * te - c);
    endfunction

    task automatic sweep(input int md, input int t, input int c0, input int c1,
                         input int c2, input int c3, input bit dn, input int nc);
        int cs[4];
        int em, te, w;
        string tc, tw;
        cs = '{c0, c1, c2, c3};
        em = (md == 3) ? 0 : md;
        te = (em == 1) ? c0 : t;
        tc = (md == 3) ? "R9" : (em >= 4) ? "R4" : (em == 1) ? "R3" : "R2";
        tw = (md == 3) ? "R9" : (em >= 4) ? "R8" : (em == 2) ? "R7" : "R6";
        do_reset();
        period = 8'(t);
        cmp = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
        count_down = dn;
        write_cfg(3'(md), 4'h0, 2'b00, 4'h0, 1'b0);
        @(negedge clk);
        run_en = 1'b1;
        for (int n = 0; n < nc; n++) begin
            #1;
            chk($sformatf("%s count mode=%0d n=%0d", tc, md, n), int'(count_o), e_cnt(em, te, n, dn));
            chk($sformatf("%s dir mode=%0d n=%0d", tc, md, n), int'(dir_o), e_dir(em, te, n, dn));
            chk($sformatf("R5 ovf mode=%0d n=%0d", md, n), int'(ovf_o), e_ovf(em, te, n, dn));
            if (!dn) begin
                w = 0;
                for (int i = 0; i < 4; i++) w |= e_wave(em, te, cs[i], n) << i;
                chk($sformatf("%s wave mode=%0d n=%0d", tw, md, n), int'(wave_out), w);
            end
            @(negedge clk);
        end
        run_en = 1'b0;
    endtask

    initial begin
        // R1 reset state
        do_reset();
        #1;
        chk("R1 count", int'(count_o), 0);
        chk("R1 dir", int'(dir_o), 0);
        chk("R1 ovf", int'(ovf_o), 0);
        chk("R1 wave", int'(wave_out), 0);
        chk("R1 circ_cc", int'(circ_cc_o), 0);
        chk("R1 circ_per", int'(circ_per_o), 0);

        // R1 buffers reset to zero: updates with double buffering copy zeros
        @(negedge clk);
        dbuf_en = 1'b1; period = 8'd2; cmp = '1; run_en = 1'b1;
        for (int n = 0; n < 7; n++) begin
            #1;
            chk("R1 buffered count", int'(count_o), n % 3);
            chk("R1 buffered circ", int'({circ_per_o, circ_cc_o}), 0);
            chk("R1 buffered wave", int'(wave_out), 0);
            @(negedge clk);
        end
        run_en = 1'b0;

        // Mode sweeps
        sweep(0, 5, 0, 2, 5, 3, 1'b0, 40);
        sweep(1, 9, 6, 1, 4, 6, 1'b0, 40);
        sweep(2, 7, 0, 3, 7, 5, 1'b0, 40);
        sweep(3, 4, 1, 2, 3, 4, 1'b0, 40);
        sweep(4, 6, 1, 2, 3, 5, 1'b0, 40);
        sweep(5, 6, 1, 2, 3, 5, 1'b0, 40);
        sweep(6, 6, 1, 2, 3, 5, 1'b0, 40);
        sweep(7, 6, 1, 2, 3, 5, 1'b0, 40);
        sweep(6, 3, 1, 2, 1, 2, 1'b0, 30);
        sweep(0, 5, 0, 0, 0, 0, 1'b1, 30);
        sweep(2, 4, 0, 0, 0, 0, 1'b1, 20);

        // R13 halt at TOP: no overflow while stopped
        do_reset();
        period = 8'd5; cmp = '1;
        write_cfg(3'd0, 4'h0, 2'b00, 4'h0, 1'b0);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        run_en = 1'b0;
        for (int n = 0; n < 4; n++) begin
            #1;
            chk("R13 held count", int'(count_o), 5);
            chk("R13 no ovf while halted", int'(ovf_o), 0);
            @(negedge clk);
        end
        run_en = 1'b1;
        #1;
        chk("R5 ovf after resume", int'(ovf_o), 1);
        @(negedge clk);
        #1;
        chk("R2 wrap after resume", int'(count_o), 0);
        run_en = 1'b0;

        // R10 / R11 / R12 polarity and swap, direct write (dbuf off)
        do_reset();
        period = 8'd5; cmp = '1;
        write_cfg(3'd0, 4'b0001, 2'b00, 4'h0, 1'b0);
        #1; chk("R10 pol only", int'(wave_out), 4'b0001);
        write_cfg(3'd0, 4'b0001, 2'b01, 4'h0, 1'b0);
        #1; chk("R11 swap pair0", int'(wave_out), 4'b0010);
        write_cfg(3'd0, 4'b0100, 2'b10, 4'h0, 1'b0);
        #1; chk("R11 swap pair1", int'(wave_out), 4'b1000);
        write_cfg(3'd0, 4'b1110, 2'b11, 4'b0110, 1'b1);
        #1;
        chk("R11 swap both", int'(wave_out), 4'b1101);
        chk("R12 direct circ", int'({circ_per_o, circ_cc_o}), 5'b10110);

        // R10 polarity after waveform, R11 swap of a live waveform
        do_reset();
        period = 8'd5; cmp = {8'hFF, 8'hFF, 8'hFF, 8'h00};
        write_cfg(3'd2, 4'b0001, 2'b00, 4'h0, 1'b0);
        run_en = 1'b1;
        #1; chk("R10 inverted low", int'(wave_out), 4'b0001);
        @(negedge clk);
        #1; chk("R10 inverted high", int'(wave_out), 4'b0000);
        run_en = 1'b0;
        write_cfg(3'd2, 4'b0000, 2'b01, 4'h0, 1'b0);
        #1; chk("R11 swapped wave", int'(wave_out), 4'b0010);

        // R12 double-buffered write, including a mode change to dual slope
        do_reset();
        period = 8'd5; cmp = '1;
        write_cfg(3'd0, 4'h0, 2'b00, 4'h0, 1'b0);
        dbuf_en = 1'b1;
        run_en = 1'b1;
        for (int n = 0; n < 14; n++) begin
            #1;
            if (n >= 3 && n <= 5) begin
                chk("R12 held before update", int'({circ_per_o, circ_cc_o}), 0);
                chk("R12 pol held before update", int'(wave_out), 0);
            end
            if (n == 6) begin
                chk("R12 circ after update", int'({circ_per_o, circ_cc_o}), 5'b11010);
                chk("R12 pol after update", int'(wave_out), 4'b0011);
                chk("R12 count at switch", int'(count_o), 0);
            end
            if (n == 11) begin
                chk("R4 new mode reaches top", int'(count_o), 5);
                chk("R4 dir at top", int'(dir_o), 0);
            end
            if (n == 12) begin
                chk("R4 new mode turns down", int'(count_o), 4);
                chk("R4 dir after top", int'(dir_o), 1);
            end
            if (n == 2) begin
                cfg_mode = 3'd4; cfg_pol = 4'b0011; cfg_swap = 2'b00;
                cfg_circ_cc = 4'b1010; cfg_circ_per = 1'b1;
                cfg_we = 1'b1;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        run_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule